// File: doc/BRIEF.md
# Multi-level translation walker

This block turns a 64-bit virtual address into a real page address. It walks a chain of in-memory translation tables. The chain can start at any of four depths: region-first, region-second, region-third or segment. It always ends at a page table. A request carries the virtual address, an access-space mode and a write flag. The mode picks one of three table-root elements, which are held on plain input pins.

The type field of the chosen root element gives the starting depth. Each depth has its own check that the high address bits fall within range. After that check the walker issues one 64-bit read per level on a valid/ready memory port. It waits for each response before it moves on. The walk ends in one of two ways. It returns a page-aligned real address with read/write permission bits, or it returns a fault code with a translation-exception word.

Two conditions skip the walk: translation turned off, and a root element marked as real space. In both cases the result comes back without any memory traffic.

Requests and results are valid/ready streams.
- A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the walker is idle.
- A result is held unchanged, with `res_valid` high, until `res_ready` is sampled high.
- A memory read holds its address until `mem_req_ready` accepts it.

Top module: `xlat_walker`

## Requirements
- R1: `req_ready` is high only while no walk is in progress. `busy` goes high on the cycle after a request is accepted and stays high until the result handshake. A result stays stable, with `res_valid` high, until `res_ready` accepts it.
- R2: `req_mode` selects the root element. 2'b10 selects `elem_sec` and 2'b11 selects `elem_home`. 2'b00 and 2'b01 both select `elem_pri`.
- R3: The walk is skipped in two cases. With `xlate_en` low, the result is the virtual address with bits 11:0 cleared, permission 2'b11 and no memory read. A root element with bit 5 set gives the same result, provided its range check passes.
- R4: Root element bits 3:2 give the starting table. 3 is region-first, 2 region-second, 1 region-third and 0 segment. Bits 63:12 give that table's origin, and the first read goes to origin plus the table offset.
- R5: Table byte offsets depend on the level:
  - region-first: (va>>50)&0x3FF8
  - region-second: (va>>39)&0x3FF8
  - region-third: (va>>28)&0x3FF8
  - segment: (va>>17)&0x3FF8
  - page: (va>>9)&0x7F8
- R6: If any of the following address bits is set, the request faults with code 0x12 and no read is made:
  - va[63:53] when starting at region-second
  - va[63:42] when starting at region-third
  - va[63:31] when starting at segment
- R7: An entry read from a region or segment table faults with code 0x10 if its bit 5 is set. It faults with code 0x12 if its bits 3:2 differ from the expected type (3 in a region-first table, down to 0 in a segment table). Otherwise, the next origin is bits 63:12 of a region entry or bits 63:11 of a segment entry.
- R8: A page entry with bit 10 set faults with code 0x11. Otherwise, the real address is entry bits 63:12 with 12 zero bits below them. Permission is 2'b01 (read only) when entry bit 9 is set and 2'b11 when it is clear; bit 0 means read and bit 1 means write.
- R9: A write through a page entry with bit 9 set faults with code 0x04, and bit 2 of the exception word is set.
- R10: On a fault, `res_xword` is the virtual address with bits 11:0 cleared, ORed with the mode bits in bits 1:0: 0 for primary, 2 for secondary, 3 for home. `res_raddr` and `res_perm` are zero on a fault.
- R11: A walk makes exactly one read per level it visits. A pending read holds `mem_req_addr` stable until it is accepted. No read is issued while a result is waiting.
- R12: Two checks take priority when both could apply. A page entry that is both invalid and read only reports code 0x11 on a write. A root element that is real-space but fails its range check reports 0x12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xlate_en | input | 1 | Translation enable; low means the real address equals the virtual address |
| elem_pri | input | 64 | Primary root element |
| elem_sec | input | 64 | Secondary root element |
| elem_home | input | 64 | Home root element |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_vaddr | input | 64 | Virtual address |
| req_mode | input | 2 | Access-space mode |
| req_write | input | 1 | Access is a write |
| busy | output | 1 | Walk or result in progress |
| mem_req_valid | output | 1 | Table read request valid |
| mem_req_ready | input | 1 | Table read request accepted |
| mem_req_addr | output | 64 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Table read data valid |
| mem_rsp_data | input | 64 | Table entry |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result accepted |
| res_fault | output | 1 | Result is a fault |
| res_code | output | 8 | Fault code |
| res_raddr | output | 64 | Real page address |
| res_perm | output | 2 | Permission: bit 0 read, bit 1 write |
| res_xword | output | 64 | Translation-exception word |

## Verification
Some rules can fire on the same entry in the same response cycle, or on the same request at acceptance. The page-invalid and write-protection checks both apply to one page entry. The range check and the real-space bypass both apply at acceptance. The bench provokes the first by writing through a page entry with both bit 10 and bit 9 set, and expects code 0x11 with bit 2 of the word clear. It provokes the second with a real-space segment root and an address above bit 30, and expects code 0x12 with no memory read. The expected values come from an independent table-walking model over the bench's own memory. Random-looking ready patterns on the memory and result ports apply back-pressure throughout.

// File: rtl/xlat_walker_pkg.sv
package xlat_walker_pkg;
  localparam int AW      = 64;
  localparam int PG_BITS = 12;
  localparam int CODE_W  = 8;
  localparam int LVL_W   = 3;

  // walk depth: 4 region-first .. 1 segment, 0 page
  localparam logic [LVL_W-1:0] LV_PAGE = 3'd0;
  localparam logic [LVL_W-1:0] LV_SEG  = 3'd1;
  localparam logic [LVL_W-1:0] LV_R3   = 3'd2;
  localparam logic [LVL_W-1:0] LV_R2   = 3'd3;
  localparam logic [LVL_W-1:0] LV_R1   = 3'd4;

  localparam logic [CODE_W-1:0] XC_PROT  = 8'h04;
  localparam logic [CODE_W-1:0] XC_SEGX  = 8'h10;
  localparam logic [CODE_W-1:0] XC_PAGEX = 8'h11;
  localparam logic [CODE_W-1:0] XC_SPEC  = 8'h12;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_DONE} walk_st_e;

  function automatic logic [AW-1:0] tbl_off(input logic [LVL_W-1:0] lv, input logic [AW-1:0] va);
    case (lv)
      LV_R1:   tbl_off = (va >> 50) & 64'h3FF8;
      LV_R2:   tbl_off = (va >> 39) & 64'h3FF8;
      LV_R3:   tbl_off = (va >> 28) & 64'h3FF8;
      LV_SEG:  tbl_off = (va >> 17) & 64'h3FF8;
      default: tbl_off = (va >> 9)  & 64'h07F8;
    endcase
  endfunction
endpackage

// File: rtl/xlat_root_sel.sv
module xlat_root_sel
  import xlat_walker_pkg::*;
(
  input  logic [1:0]       mode,
  input  logic [AW-1:0]    vaddr,
  input  logic [AW-1:0]    root_pri,
  input  logic [AW-1:0]    root_sec,
  input  logic [AW-1:0]    root_home,
  output logic [LVL_W-1:0] start_lvl,
  output logic [AW-1:0]    first_addr,
  output logic             range_bad,
  output logic             real_space,
  output logic [1:0]       mode_bits
);
  logic [AW-1:0] root;
  logic          unused_root;

  always_comb begin
    case (mode)
      2'b10:   begin root = root_sec;  mode_bits = 2'd2; end
      2'b11:   begin root = root_home; mode_bits = 2'd3; end
      default: begin root = root_pri;  mode_bits = 2'd0; end
    endcase
  end

  assign start_lvl  = {1'b0, root[3:2]} + 3'd1;
  assign real_space = root[5];
  assign first_addr = {root[AW-1:PG_BITS], {PG_BITS{1'b0}}} + tbl_off(start_lvl, vaddr);
  assign unused_root = ^{root[PG_BITS-1:6], root[4], root[1:0]};

  always_comb begin
    case (root[3:2])
      2'd2:    range_bad = |vaddr[63:53];
      2'd1:    range_bad = |vaddr[63:42];
      2'd0:    range_bad = |vaddr[63:31];
      default: range_bad = 1'b0;
    endcase
  end
endmodule

// File: rtl/xlat_entry_dec.sv
module xlat_entry_dec
  import xlat_walker_pkg::*;
(
  input  logic [LVL_W-1:0]  lvl,
  input  logic [AW-1:0]     vaddr,
  input  logic [AW-1:0]     entry,
  input  logic              is_write,
  output logic              fault,
  output logic [CODE_W-1:0] code,
  output logic              prot,
  output logic              final_hit,
  output logic [AW-1:0]     real_addr,
  output logic [1:0]        perm,
  output logic [LVL_W-1:0]  next_lvl,
  output logic [AW-1:0]     next_addr
);
  logic [LVL_W-1:0] lvl_m1;
  logic [AW-1:0]    origin;
  logic             unused_entry;

  assign lvl_m1       = lvl - 3'd1;
  assign next_lvl     = lvl_m1;
  assign origin       = (lvl == LV_SEG) ? {entry[AW-1:11], 11'b0}
                                        : {entry[AW-1:PG_BITS], {PG_BITS{1'b0}}};
  assign next_addr    = origin + tbl_off(lvl_m1, vaddr);
  assign real_addr    = {entry[AW-1:PG_BITS], {PG_BITS{1'b0}}};
  assign unused_entry = ^{entry[8:6], entry[4], entry[1:0]};

  always_comb begin
    fault     = 1'b0;
    code      = '0;
    prot      = 1'b0;
    final_hit = 1'b0;
    perm      = 2'b00;
    if (lvl != LV_PAGE) begin
      if (entry[5]) begin
        fault = 1'b1; code = XC_SEGX;
      end else if (entry[3:2] != lvl_m1[1:0]) begin
        fault = 1'b1; code = XC_SPEC;
      end
    end else if (entry[10]) begin
      fault = 1'b1; code = XC_PAGEX;
    end else if (entry[9] && is_write) begin
      fault = 1'b1; code = XC_PROT; prot = 1'b1;
    end else begin
      final_hit = 1'b1;
      perm      = {~entry[9], 1'b1};
    end
  end
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xlat_walker_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xlate_en,
  input  logic [AW-1:0]     elem_pri,
  input  logic [AW-1:0]     elem_sec,
  input  logic [AW-1:0]     elem_home,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AW-1:0]     req_vaddr,
  input  logic [1:0]        req_mode,
  input  logic              req_write,
  output logic              busy,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [AW-1:0]     mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [AW-1:0]     mem_rsp_data,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_fault,
  output logic [CODE_W-1:0] res_code,
  output logic [AW-1:0]     res_raddr,
  output logic [1:0]        res_perm,
  output logic [AW-1:0]     res_xword
);
  walk_st_e          st;
  logic [LVL_W-1:0]  lvl_q;
  logic [AW-1:0]     addr_q, va_q, raddr_q, word_q;
  logic [1:0]        mb_q, perm_q;
  logic              wr_q, fault_q;
  logic [CODE_W-1:0] code_q;
  logic [AW-1:0]     va_pg;

  logic [LVL_W-1:0]  s_lvl;
  logic [AW-1:0]     s_addr;
  logic              s_range_bad, s_real;
  logic [1:0]        s_mb;

  logic              d_fault, d_prot, d_final;
  logic [CODE_W-1:0] d_code;
  logic [AW-1:0]     d_raddr, d_addr;
  logic [1:0]        d_perm;
  logic [LVL_W-1:0]  d_lvl;

  assign va_pg = {req_vaddr[AW-1:PG_BITS], {PG_BITS{1'b0}}};

  xlat_root_sel u_root (
    .mode(req_mode), .vaddr(req_vaddr), .root_pri(elem_pri), .root_sec(elem_sec),
    .root_home(elem_home), .start_lvl(s_lvl), .first_addr(s_addr),
    .range_bad(s_range_bad), .real_space(s_real), .mode_bits(s_mb)
  );

  xlat_entry_dec u_dec (
    .lvl(lvl_q), .vaddr(va_q), .entry(mem_rsp_data), .is_write(wr_q),
    .fault(d_fault), .code(d_code), .prot(d_prot), .final_hit(d_final),
    .real_addr(d_raddr), .perm(d_perm), .next_lvl(d_lvl), .next_addr(d_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; lvl_q <= '0; addr_q <= '0; va_q <= '0; mb_q <= '0; wr_q <= 1'b0;
      fault_q <= 1'b0; code_q <= '0; raddr_q <= '0; word_q <= '0; perm_q <= '0;
    end else begin
      case (st)
        ST_IDLE: if (req_valid) begin
          va_q <= va_pg; mb_q <= s_mb; wr_q <= req_write;
          fault_q <= 1'b0; code_q <= '0; word_q <= '0; raddr_q <= va_pg; perm_q <= 2'b11;
          if (xlate_en && s_range_bad) begin
            fault_q <= 1'b1; code_q <= XC_SPEC; word_q <= va_pg | {62'b0, s_mb};
            raddr_q <= '0; perm_q <= 2'b00; st <= ST_DONE;
          end else if (!xlate_en || s_real) begin
            st <= ST_DONE;
          end else begin
            lvl_q <= s_lvl; addr_q <= s_addr; st <= ST_ISSUE;
          end
        end
        ST_ISSUE: if (mem_req_ready) st <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          if (d_fault) begin
            fault_q <= 1'b1; code_q <= d_code; word_q <= va_q | {61'b0, d_prot, mb_q};
            raddr_q <= '0; perm_q <= 2'b00; st <= ST_DONE;
          end else if (d_final) begin
            raddr_q <= d_raddr; perm_q <= d_perm; st <= ST_DONE;
          end else begin
            lvl_q <= d_lvl; addr_q <= d_addr; st <= ST_ISSUE;
          end
        end
        default: if (res_ready) st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (st == ST_IDLE);
  assign busy          = (st != ST_IDLE);
  assign mem_req_valid = (st == ST_ISSUE);
  assign mem_req_addr  = addr_q;
  assign res_valid     = (st == ST_DONE);
  assign res_fault     = fault_q;
  assign res_code      = code_q;
  assign res_raddr     = raddr_q;
  assign res_perm      = perm_q;
  assign res_xword     = word_q;

  AST_BUSY_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready); // R1
  AST_ACCEPT_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> busy); // R1
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_raddr) && $stable(res_xword) && $stable(res_code)); // R1
  AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R11
  AST_NO_READ_WITH_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !mem_req_valid); // R11
  AST_FAULT_CLEARS_PERM: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_fault |-> res_perm == 2'b00 && res_raddr == '0); // R10
  AST_REAL_PAGE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_fault |-> res_raddr[PG_BITS-1:0] == '0 && res_perm[0]); // R8
endmodule

// File: tb/xlat_walker_test.sv
`timescale 1ns/1ps
module xlat_walker_test;
  typedef struct packed {
    logic        fault;
    logic [7:0]  code;
    logic [63:0] raddr;
    logic [63:0] word;
    logic [1:0]  perm;
    logic [31:0] reads;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic xlate_en = 1'b0;
  logic [63:0] elem_pri = '0, elem_sec = '0, elem_home = '0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [63:0] req_vaddr = '0;
  logic [1:0] req_mode = '0;
  logic req_ready, busy, mem_req_valid, mem_rsp_valid = 1'b0, mem_req_ready = 1'b0;
  logic [63:0] mem_req_addr, mem_rsp_data = '0;
  logic res_valid, res_ready = 1'b0, res_fault;
  logic [7:0] res_code;
  logic [63:0] res_raddr, res_xword;
  logic [1:0] res_perm;

  logic [63:0] mem [logic [63:0]];
  exp_t  expq[$];
  string tagq[$];
  int n_chk = 0, n_bad = 0, rd_cnt = 0;
  bit summary_done = 0;

  initial forever #2.5 clk = ~clk;

  xlat_walker uut (
    .clk(clk), .rst_n(rst_n), .xlate_en(xlate_en), .elem_pri(elem_pri), .elem_sec(elem_sec),
    .elem_home(elem_home), .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_mode(req_mode), .req_write(req_write), .busy(busy), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .res_valid(res_valid), .res_ready(res_ready), .res_fault(res_fault),
    .res_code(res_code), .res_raddr(res_raddr), .res_perm(res_perm), .res_xword(res_xword)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!summary_done) begin
      summary_done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic logic [63:0] off(input int lv, input logic [63:0] va);
    case (lv)
      4: return (va >> 50) & 64'h3FF8;
      3: return (va >> 39) & 64'h3FF8;
      2: return (va >> 28) & 64'h3FF8;
      1: return (va >> 17) & 64'h3FF8;
      default: return (va >> 9) & 64'h7F8;
    endcase
  endfunction

  function automatic logic [63:0] rd(input logic [63:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  function automatic exp_t model(input logic [63:0] va, input logic wr, input logic [1:0] md,
                                 input logic en, input logic [63:0] el);
    exp_t e;
    logic [63:0] vp, org, ent;
    logic [63:0] mbits;
    int lv;
    bit bad;
    vp = {va[63:12], 12'h000};
    mbits = (md == 2'b10) ? 64'd2 : (md == 2'b11) ? 64'd3 : 64'd0;
    e = '0; e.raddr = vp; e.perm = 2'b11;
    if (!en) return e;
    case (el[3:2])
      2'd2: bad = |va[63:53];
      2'd1: bad = |va[63:42];
      2'd0: bad = |va[63:31];
      default: bad = 0;
    endcase
    if (bad) begin
      e.fault = 1; e.code = 8'h12; e.word = vp | mbits; e.raddr = '0; e.perm = '0;
      return e;
    end
    if (el[5]) return e;
    lv = int'(el[3:2]) + 1;
    org = {el[63:12], 12'h000};
    for (int k = 0; k < 5; k++) begin
      ent = rd(org + off(lv, va));
      e.reads = e.reads + 1;
      if (lv > 0) begin
        if (ent[5] || ent[3:2] != 2'(lv - 1)) begin
          e.fault = 1; e.code = ent[5] ? 8'h10 : 8'h12; e.word = vp | mbits;
          e.raddr = '0; e.perm = '0;
          return e;
        end
        org = (lv == 1) ? {ent[63:11], 11'h0} : {ent[63:12], 12'h000};
        lv--;
      end else begin
        if (ent[10] || (ent[9] && wr)) begin
          e.fault = 1; e.code = ent[10] ? 8'h11 : 8'h04;
          e.word = vp | mbits | (ent[10] ? 64'd0 : 64'd4); e.raddr = '0; e.perm = '0;
          return e;
        end
        e.raddr = {ent[63:12], 12'h000};
        e.perm = {~ent[9], 1'b1};
        return e;
      end
    end
    return e;
  endfunction

  task automatic build(input logic [63:0] va, input int sl, input logic [63:0] base,
                       input logic [63:0] frame, input logic [63:0] pfl, output logic [63:0] el);
    for (int lv = sl; lv >= 0; lv--) begin
      if (lv == 0) mem[base + off(0, va)] = frame | pfl;
      else mem[base + (64'(lv) << 16) + off(lv, va)] = (base + (64'(lv - 1) << 16)) | (64'(lv - 1) << 2);
    end
    el = (base + (64'(sl) << 16)) | (64'(sl - 1) << 2);
  endtask

  function automatic logic [63:0] ent_addr(input logic [63:0] base, input int lv, input logic [63:0] va);
    return base + (64'(lv) << 16) + off(lv, va);
  endfunction

  // driver: pushes expected result, then presents the request
  task automatic do_req(input string tag, input logic [63:0] va, input logic wr,
                        input logic [1:0] md, input logic en);
    logic [63:0] el;
    el = (md == 2'b10) ? elem_sec : (md == 2'b11) ? elem_home : elem_pri;
    @(negedge clk);
    xlate_en = en; req_vaddr = va; req_write = wr; req_mode = md; req_valid = 1'b1;
    expq.push_back(model(va, wr, md, en, el));
    tagq.push_back(tag);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy && !req_ready, "R1 busy and not ready after accept", {62'b0, busy, req_ready}, 64'h2);
    while (busy) @(negedge clk);
  endtask

  // memory responder
  initial begin
    int cyc = 0;
    bit pend = 0;
    logic [63:0] pa = '0;
    forever begin
      @(negedge clk);
      cyc++;
      if (pend) begin mem_rsp_valid = 1'b1; mem_rsp_data = rd(pa); pend = 0; end
      else begin mem_rsp_valid = 1'b0; mem_rsp_data = 64'hDEAD_BEEF_DEAD_BEEF; end
      mem_req_ready = (cyc % 3) != 1;
      if (rst_n && mem_req_valid && mem_req_ready) begin pa = mem_req_addr; pend = 1; rd_cnt++; end
    end
  end

  // monitor: pops and compares results
  initial begin
    int mc = 0;
    exp_t ex;
    string tg;
    forever begin
      @(negedge clk);
      mc++;
      res_ready = (mc % 4) != 2;
      if (rst_n && res_valid && res_ready) begin
        if (expq.size() == 0) chk(0, "R1 unexpected result", 64'd1, 64'd0);
        else begin
          ex = expq.pop_front(); tg = tagq.pop_front();
          chk(res_fault == ex.fault, {tg, " fault"}, {63'b0, res_fault}, {63'b0, ex.fault});
          if (ex.fault) begin
            chk(res_code == ex.code, {tg, " code"}, {56'b0, res_code}, {56'b0, ex.code});
            chk(res_xword == ex.word, {tg, " R10 word"}, res_xword, ex.word);
          end else begin
            chk(res_raddr == ex.raddr, {tg, " raddr"}, res_raddr, ex.raddr);
            chk(res_perm == ex.perm, {tg, " perm"}, {62'b0, res_perm}, {62'b0, ex.perm});
          end
          chk(rd_cnt == int'(ex.reads), {tg, " R11 read count"}, 64'(rd_cnt), 64'(ex.reads));
        end
        rd_cnt = 0;
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [63:0] e1, e2, e3, e4, a;
    logic [63:0] va1, va2, va3, va4;
    va1 = 64'h1234_5678_9ABC_D000;
    va2 = 64'h0000_0000_5A5A_3000;
    va3 = 64'h001F_0F0F_1234_5000;
    va4 = 64'h0000_03AB_CDEF_1000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !busy && !res_valid && !mem_req_valid, "R1 reset state",
        {60'b0, req_ready, busy, res_valid, mem_req_valid}, 64'h8);

    build(va1, 4, 64'h0100_0000, 64'h0000_00AB_CDE0_0000, 64'h0, e1);
    build(va2, 1, 64'h0200_0000, 64'h0000_0000_0007_7000, 64'h200, e2);
    build(va3, 3, 64'h0300_0000, 64'h0000_0123_4560_0000, 64'h0, e3);
    build(va4, 2, 64'h0400_0000, 64'h0000_0000_0ABC_0000, 64'h0, e4);
    elem_pri = e1; elem_sec = e2; elem_home = e3;

    do_req("R4 R5 region-first walk write", va1, 1'b1, 2'b00, 1'b1);
    do_req("R3 translation off", va1 | 64'hABC, 1'b1, 2'b00, 1'b0);
    do_req("R2 R8 secondary read-only read", va2 | 64'h123, 1'b0, 2'b10, 1'b1);
    do_req("R9 R10 write to read-only page", va2, 1'b1, 2'b10, 1'b1);
    do_req("R2 R4 home region-second walk", va3, 1'b0, 2'b11, 1'b1);
    do_req("R6 R10 region-second range", va3 | (64'h1 << 60), 1'b0, 2'b11, 1'b1);
    elem_pri = e4;
    do_req("R4 R5 region-third walk", va4, 1'b1, 2'b00, 1'b1);
    do_req("R6 region-third range", va4 | (64'h1 << 45), 1'b0, 2'b00, 1'b1);
    elem_pri = e2;
    do_req("R6 R2 segment range mode 01", va2 | (64'h1 << 31), 1'b0, 2'b01, 1'b1);
    elem_pri = e1;

    a = ent_addr(64'h0100_0000, 3, va1);
    mem[a] = mem[a] | 64'h20;
    do_req("R7 region entry invalid", va1, 1'b0, 2'b00, 1'b1);
    mem[a] = mem[a] & ~64'h20;
    a = ent_addr(64'h0100_0000, 2, va1);
    mem[a] = mem[a] | 64'hC;
    do_req("R7 region entry type mismatch", va1, 1'b0, 2'b00, 1'b1);
    mem[a] = mem[a] & ~64'hC | 64'h4;
    a = ent_addr(64'h0100_0000, 1, va1);
    mem[a] = mem[a] | 64'h20;
    do_req("R7 segment entry invalid", va1, 1'b0, 2'b00, 1'b1);
    mem[a] = mem[a] & ~64'h20;
    a = ent_addr(64'h0100_0000, 0, va1);
    mem[a] = mem[a] | 64'h400;
    do_req("R8 page entry invalid", va1, 1'b0, 2'b00, 1'b1);
    mem[a] = mem[a] | 64'h200;
    do_req("R12 invalid beats protection", va1, 1'b1, 2'b00, 1'b1);
    mem[a] = mem[a] & ~64'h600;
    do_req("R5 R8 restored walk read", va1, 1'b0, 2'b00, 1'b1);

    elem_sec = e2 | 64'h20;
    do_req("R3 real-space root", va2 | 64'h7, 1'b1, 2'b10, 1'b1);
    do_req("R12 range beats real-space", va2 | (64'h1 << 40), 1'b0, 2'b10, 1'b1);

    repeat (10) @(negedge clk);
    chk(expq.size() == 0, "R1 all results returned", 64'(expq.size()), 64'd0);
    finish_run();
  end
endmodule